// File: doc/BRIEF.md
# Cursor Generator Host Register Port

This block is the host-facing side of a hardware cursor generator. The host reaches everything inside the block through four 16-bit access ports: two that load an internal 16-bit index one byte at a time, one that carries single bytes to and from a small bank of control registers, and one that carries full words to and from a 512-word cursor pattern memory. After the index is loaded, each data access works on the location the index names, and the index then moves on by one. One index load can therefore be followed by a burst through consecutive control registers or pattern words.

The stored values are always visible to the pixel generator. The command byte drives decoded enable and mode outputs. The six 12-bit coordinates (cursor position plus the crosshair window origin and size) appear as parallel buses. A second, independent read port into the pattern memory lets the pixel generator fetch words without disturbing the host. A host read returns its result on `rdata` at the clock edge that services the request, and `rdata` then holds that value until the next serviced read.

Top module: `cursor_regif`

## Requirements
- R1: A write on the index-low port loads index bits 7:0 from `wdata[7:0]` and keeps bits 15:8. A write on the index-high port loads bits 15:8 and keeps bits 7:0. A read on either index port returns that index byte in `rdata[7:0]` with `rdata[15:8]` zero, and the index does not change.
- R2: Every serviced read or write on the control data port or the pattern data port adds one to the index after the access. The index wraps from 0xFFFF to 0x0000.
- R3: Control index 0x00 holds the 8-bit command. Indices 0x01 to 0x0C hold low/high byte pairs (low at the odd index) for six coordinates, in this order: cursor X, cursor Y, window X, window Y, window width, window height. After a write, the matching output shows the new value from the next cycle on.
- R4: Each coordinate high register keeps only 4 bits, so every coordinate is 12 bits wide. Reading a high register returns those 4 bits with bits 7:4 zero.
- R5: A control write uses only `wdata[7:0]`. A control read returns the register in `rdata[7:0]` with `rdata[15:8]` zero.
- R6: For control indices 0x0D to 0xFFFF, a read returns zero and a write changes no stored value. The index still advances.
- R7: A pattern write at an index below 0x200 stores all 16 bits of `wdata`, and a pattern read there returns the stored word. The pixel port returns the word at `pix_addr` one clock later. When the host writes that same word in the same cycle, the pixel port returns the value from before the write.
- R8: A pattern access at an index of 0x200 or above writes nothing and a read returns zero. The index still advances.
- R9: When several port requests arrive in one cycle, only one is serviced, chosen by the fixed priority index-low, index-high, control, pattern. The other requests are dropped and have no effect at all.
- R10: While reset is held, the index, all control registers and `rdata` are zero, so the cursor and the crosshair are disabled.
- R11: The command outputs follow the stored command byte: `cur_en` is bit 6, `xhair_en` is bit 5, `blend_or` is bit 4, `mux_mode` is bits 3:2 and `xhair_thick` is bits 1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | 1 = write, 0 = read, for the requesting port |
| req_alo | input | 1 | Access request on the index-low port |
| req_ahi | input | 1 | Access request on the index-high port |
| req_reg | input | 1 | Access request on the control data port |
| req_map | input | 1 | Access request on the pattern data port |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| cur_en | output | 1 | Cursor enable |
| xhair_en | output | 1 | Crosshair enable |
| blend_or | output | 1 | Cursor combine mode (1 = OR) |
| mux_mode | output | 2 | Pixel multiplex mode |
| xhair_thick | output | 2 | Crosshair thickness code |
| cur_x | output | 12 | Cursor X |
| cur_y | output | 12 | Cursor Y |
| win_x | output | 12 | Crosshair window X |
| win_y | output | 12 | Crosshair window Y |
| win_w | output | 12 | Crosshair window width |
| win_h | output | 12 | Crosshair window height |
| pix_addr | input | 9 | Pixel-side pattern read address |
| pix_data | output | 16 | Pixel-side pattern word, one cycle after the address |

## Verification
The in-line properties are checked on every cycle. They cover the low-byte load of the index, the single-step advance after each data access, the zero upper byte on control reads, zero read data for pattern reads out of range, a high-priority write keeping the other index byte unchanged, and writes to unimplemented control indices leaving every output stable. Other behaviour only shows across whole scenarios: the index wrapping at 0xFFFF, the coordinate register layout and the 4-bit truncation of the high registers, pattern words surviving a full burst fill, the pixel port returning the old word when the host writes it in the same cycle, and the full pattern of drops when all four requests collide.

// File: rtl/cursor_regif_pkg.sv
package cursor_regif_pkg;

   // Serviced port for one cycle; declaration order is not priority
   typedef enum logic [1:0] {
      GNT_ALO = 2'd0,
      GNT_AHI = 2'd1,
      GNT_REG = 2'd2,
      GNT_MAP = 2'd3
   } gnt_e;

   // Number of coordinate registers behind the command byte
   localparam int unsigned NUM_COORD = 6;

   typedef struct packed {
      logic       cur_en;
      logic       xhair_en;
      logic       blend_or;
      logic [1:0] mux_mode;
      logic [1:0] thick;
   } cmd_view_t;

   function automatic cmd_view_t decode_cmd(input logic [7:0] c);
      cmd_view_t v;
      v.cur_en   = c[6];
      v.xhair_en = c[5];
      v.blend_or = c[4];
      v.mux_mode = c[3:2];
      v.thick    = c[1:0];
      return v;
   endfunction

endpackage

// File: rtl/cri_pointer.sv
module cri_pointer #(
   parameter int unsigned PTR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_lo,
   input  logic             ld_hi,
   input  logic             step,
   input  logic [7:0]       byte_in,
   output logic [PTR_W-1:0] ptr_q
);

   generate
      if (PTR_W <= 8 || PTR_W > 16) begin : g_bad_w
         $error("cri_pointer: PTR_W must be 9..16");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (ld_lo) begin
         ptr_q[7:0] <= byte_in;
      end else if (ld_hi) begin
         ptr_q[PTR_W-1:8] <= byte_in[PTR_W-9:0];
      end else if (step) begin
         ptr_q <= ptr_q + PTR_W'(1);
      end
   end

   AST_ALO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo |=> ptr_q[7:0] == $past(byte_in)); // R1

endmodule

// File: rtl/cri_ctrl_file.sv
module cri_ctrl_file #(
   parameter int unsigned PTR_W     = 16,
   parameter int unsigned COORD_W   = 12,
   parameter int unsigned NUM_COORD = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [PTR_W-1:0]               idx,
   input  logic [7:0]                     wbyte,
   output logic [7:0]                     rbyte,
   output logic [7:0]                     cmd_q,
   output logic [NUM_COORD*COORD_W-1:0]   coords
);

   localparam int unsigned HI_W     = COORD_W - 8;
   localparam int unsigned LAST_IDX = 2 * NUM_COORD;

   generate
      if (COORD_W <= 8 || COORD_W > 16) begin : g_bad_cw
         $error("cri_ctrl_file: COORD_W must be 9..16");
      end
   endgenerate

   logic [7:0]      lo_q [NUM_COORD];
   logic [HI_W-1:0] hi_q [NUM_COORD];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cmd_q <= '0;
      else if (wr_en && idx == '0)         cmd_q <= wbyte;
   end

   generate
      for (genvar k = 0; k < NUM_COORD; k++) begin : g_coord
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_q[k] <= '0;
               hi_q[k] <= '0;
            end else if (wr_en) begin
               if (idx == PTR_W'(1 + 2*k)) lo_q[k] <= wbyte;
               if (idx == PTR_W'(2 + 2*k)) hi_q[k] <= wbyte[HI_W-1:0];
            end
         end
         assign coords[k*COORD_W +: COORD_W] = {hi_q[k], lo_q[k]};
      end
   endgenerate

   always_comb begin
      rbyte = '0;
      if (idx == '0) rbyte = cmd_q;
      for (int k = 0; k < NUM_COORD; k++) begin
         if (idx == PTR_W'(1 + 2*k)) rbyte = lo_q[k];
         if (idx == PTR_W'(2 + 2*k)) rbyte = 8'(hi_q[k]);
      end
   end

   AST_UNIMPL_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx > PTR_W'(LAST_IDX)) |=> ($stable(coords) && $stable(cmd_q))); // R6

endmodule

// File: rtl/cri_pattern_ram.sv
module cri_pattern_ram #(
   parameter int unsigned DEPTH  = 512,
   parameter int unsigned WORD_W = 16,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_q,
   input  logic [AW-1:0]     pix_addr,
   output logic [WORD_W-1:0] pix_q
);

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("cri_pattern_ram: DEPTH must be a power of two");
      end
   endgenerate

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[host_addr] <= host_wdata;
   end

   assign host_q = mem[host_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pix_q <= '0;
      else        pix_q <= mem[pix_addr];
   end

endmodule

// File: rtl/cursor_regif.sv
module cursor_regif #(
   parameter int unsigned PTR_W     = 16,
   parameter int unsigned COORD_W   = 12,
   parameter int unsigned MAP_DEPTH = 512,
   parameter int unsigned BUS_W     = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         acc_wr,
   input  logic                         req_alo,
   input  logic                         req_ahi,
   input  logic                         req_reg,
   input  logic                         req_map,
   input  logic [BUS_W-1:0]             wdata,
   output logic [BUS_W-1:0]             rdata,
   output logic                         cur_en,
   output logic                         xhair_en,
   output logic                         blend_or,
   output logic [1:0]                   mux_mode,
   output logic [1:0]                   xhair_thick,
   output logic [COORD_W-1:0]           cur_x,
   output logic [COORD_W-1:0]           cur_y,
   output logic [COORD_W-1:0]           win_x,
   output logic [COORD_W-1:0]           win_y,
   output logic [COORD_W-1:0]           win_w,
   output logic [COORD_W-1:0]           win_h,
   input  logic [$clog2(MAP_DEPTH)-1:0] pix_addr,
   output logic [BUS_W-1:0]             pix_data
);
   import cursor_regif_pkg::*;

   localparam int unsigned MAP_AW = $clog2(MAP_DEPTH);

   generate
      if (BUS_W != 16) begin : g_bad_bus
         $error("cursor_regif: BUS_W must be 16");
      end
      if (MAP_AW >= PTR_W) begin : g_bad_map
         $error("cursor_regif: MAP_DEPTH must be below 2**PTR_W");
      end
   endgenerate

   gnt_e                        gnt;
   logic                        gnt_valid;
   logic [PTR_W-1:0]            ptr_q;
   logic                        map_in_range;
   logic [7:0]                  ctrl_rbyte;
   logic [7:0]                  cmd_q;
   logic [NUM_COORD*COORD_W-1:0] coords;
   logic [BUS_W-1:0]            map_q;
   cmd_view_t                   cview;

   // Fixed priority: index low, index high, control, pattern
   always_comb begin
      gnt_valid = 1'b1;
      gnt       = GNT_ALO;
      if (req_alo)      gnt = GNT_ALO;
      else if (req_ahi) gnt = GNT_AHI;
      else if (req_reg) gnt = GNT_REG;
      else if (req_map) gnt = GNT_MAP;
      else              gnt_valid = 1'b0;
   end

   assign map_in_range = (ptr_q < PTR_W'(MAP_DEPTH));

   cri_pointer #(.PTR_W(PTR_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_lo   (gnt_valid && gnt == GNT_ALO && acc_wr),
      .ld_hi   (gnt_valid && gnt == GNT_AHI && acc_wr),
      .step    (gnt_valid && (gnt == GNT_REG || gnt == GNT_MAP)),
      .byte_in (wdata[7:0]),
      .ptr_q   (ptr_q)
   );

   cri_ctrl_file #(.PTR_W(PTR_W), .COORD_W(COORD_W), .NUM_COORD(NUM_COORD)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (gnt_valid && gnt == GNT_REG && acc_wr),
      .idx    (ptr_q),
      .wbyte  (wdata[7:0]),
      .rbyte  (ctrl_rbyte),
      .cmd_q  (cmd_q),
      .coords (coords)
   );

   cri_pattern_ram #(.DEPTH(MAP_DEPTH), .WORD_W(BUS_W)) u_ram (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (gnt_valid && gnt == GNT_MAP && acc_wr && map_in_range),
      .host_addr  (ptr_q[MAP_AW-1:0]),
      .host_wdata (wdata),
      .host_q     (map_q),
      .pix_addr   (pix_addr),
      .pix_q      (pix_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (gnt_valid && !acc_wr) begin
         unique case (gnt)
            GNT_ALO: rdata <= BUS_W'(ptr_q[7:0]);
            GNT_AHI: rdata <= BUS_W'(ptr_q[PTR_W-1:8]);
            GNT_REG: rdata <= BUS_W'(ctrl_rbyte);
            GNT_MAP: rdata <= map_in_range ? map_q : '0;
         endcase
      end
   end

   assign cview       = decode_cmd(cmd_q);
   assign cur_en      = cview.cur_en;
   assign xhair_en    = cview.xhair_en;
   assign blend_or    = cview.blend_or;
   assign mux_mode    = cview.mux_mode;
   assign xhair_thick = cview.thick;

   assign cur_x = coords[0*COORD_W +: COORD_W];
   assign cur_y = coords[1*COORD_W +: COORD_W];
   assign win_x = coords[2*COORD_W +: COORD_W];
   assign win_y = coords[3*COORD_W +: COORD_W];
   assign win_w = coords[4*COORD_W +: COORD_W];
   assign win_h = coords[5*COORD_W +: COORD_W];

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && (gnt == GNT_REG || gnt == GNT_MAP)) |=> ptr_q == $past(ptr_q) + PTR_W'(1)); // R2

   AST_REG_RD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (req_reg && !req_alo && !req_ahi && !acc_wr) |=> rdata[BUS_W-1:8] == '0); // R5

   AST_MAP_OOR_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && gnt == GNT_MAP && !acc_wr && !map_in_range) |=> rdata == '0); // R8

   AST_PRIO_ALO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_alo && req_ahi && acc_wr) |=> ptr_q[PTR_W-1:8] == $past(ptr_q[PTR_W-1:8])); // R9

endmodule

// File: tb/cursor_regif_bench.sv
module cursor_regif_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        acc_wr, req_alo, req_ahi, req_reg, req_map;
   logic [15:0] wdata, rdata, pix_data;
   logic        cur_en, xhair_en, blend_or;
   logic [1:0]  mux_mode, xhair_thick;
   logic [11:0] cur_x, cur_y, win_x, win_y, win_w, win_h;
   logic [8:0]  pix_addr;

   always #10 clk = ~clk;

   cursor_regif u_cursor_regif (
      .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr),
      .req_alo(req_alo), .req_ahi(req_ahi), .req_reg(req_reg), .req_map(req_map),
      .wdata(wdata), .rdata(rdata),
      .cur_en(cur_en), .xhair_en(xhair_en), .blend_or(blend_or),
      .mux_mode(mux_mode), .xhair_thick(xhair_thick),
      .cur_x(cur_x), .cur_y(cur_y), .win_x(win_x), .win_y(win_y),
      .win_w(win_w), .win_h(win_h),
      .pix_addr(pix_addr), .pix_data(pix_data)
   );

   int          vectors = 0;
   int          miscompares = 0;
   logic [15:0] m_ptr;
   logic [7:0]  m_reg [13];
   logic [15:0] m_ram [512];
   logic [15:0] m_rd;
   bit          pix_ok = 1'b0;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] hmask(int i);
      return (i >= 2 && i % 2 == 0) ? 8'h0F : 8'hFF;
   endfunction

   function automatic logic [11:0] mcoord(int k);
      return {m_reg[2 + 2*k][3:0], m_reg[1 + 2*k]};
   endfunction

   task automatic check_outputs(string tag);
      chk(tag, "rdata", 32'(rdata), 32'(m_rd));
      chk("R11", "cur_en", 32'(cur_en), 32'(m_reg[0][6]));
      chk("R11", "xhair_en", 32'(xhair_en), 32'(m_reg[0][5]));
      chk("R11", "blend_or", 32'(blend_or), 32'(m_reg[0][4]));
      chk("R11", "mux_mode", 32'(mux_mode), 32'(m_reg[0][3:2]));
      chk("R11", "thick", 32'(xhair_thick), 32'(m_reg[0][1:0]));
      chk("R3", "cur_x", 32'(cur_x), 32'(mcoord(0)));
      chk("R3", "cur_y", 32'(cur_y), 32'(mcoord(1)));
      chk("R3", "win_x", 32'(win_x), 32'(mcoord(2)));
      chk("R3", "win_y", 32'(win_y), 32'(mcoord(3)));
      chk("R4", "win_w", 32'(win_w), 32'(mcoord(4)));
      chk("R4", "win_h", 32'(win_h), 32'(mcoord(5)));
   endtask

   // One clock: drive, advance the model, compare after the edge
   task automatic cycle(bit a, bit b, bit r, bit m, bit w, logic [15:0] wd,
                        logic [8:0] pa, string tag);
      logic [15:0] exp_pix;
      req_alo = a; req_ahi = b; req_reg = r; req_map = m;
      acc_wr = w; wdata = wd; pix_addr = pa;
      exp_pix = m_ram[pa];
      @(posedge clk);
      @(negedge clk);
      if (a) begin
         if (w) m_ptr[7:0] = wd[7:0]; else m_rd = {8'h00, m_ptr[7:0]};
      end else if (b) begin
         if (w) m_ptr[15:8] = wd[7:0]; else m_rd = {8'h00, m_ptr[15:8]};
      end else if (r) begin
         if (m_ptr < 16'd13) begin
            if (w) m_reg[m_ptr] = wd[7:0] & hmask(int'(m_ptr));
            else   m_rd = {8'h00, m_reg[m_ptr]};
         end else if (!w) m_rd = 16'h0000;
         m_ptr = m_ptr + 16'd1;
      end else if (m) begin
         if (m_ptr < 16'h0200) begin
            if (w) m_ram[m_ptr[8:0]] = wd; else m_rd = m_ram[m_ptr[8:0]];
         end else if (!w) m_rd = 16'h0000;
         m_ptr = m_ptr + 16'd1;
      end
      req_alo = 0; req_ahi = 0; req_reg = 0; req_map = 0;
      check_outputs(tag);
      if (pix_ok) chk("R7", "pix_data", 32'(pix_data), 32'(exp_pix));
   endtask

   task automatic set_ptr(logic [15:0] p, string tag);
      cycle(1, 0, 0, 0, 1, {8'hA5, p[7:0]}, 9'd0, tag);
      cycle(0, 1, 0, 0, 1, {8'h5A, p[15:8]}, 9'd0, tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h1F2E3D4C));
      rst_n = 0; acc_wr = 0; wdata = '0; pix_addr = '0;
      req_alo = 0; req_ahi = 0; req_reg = 0; req_map = 0;
      m_ptr = '0; m_rd = '0;
      for (int i = 0; i < 13; i++) m_reg[i] = '0;
      for (int i = 0; i < 512; i++) m_ram[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_outputs("R10");
      rst_n = 1;

      // R10: index reads back zero after reset
      cycle(1, 0, 0, 0, 0, 16'h0, 9'd0, "R10");
      cycle(0, 1, 0, 0, 0, 16'h0, 9'd0, "R10");

      // R1: byte-wise index load and readback
      cycle(1, 0, 0, 0, 1, 16'hFF34, 9'd0, "R1");
      cycle(0, 1, 0, 0, 1, 16'h0012, 9'd0, "R1");
      cycle(1, 0, 0, 0, 0, 16'h0, 9'd0, "R1");
      cycle(0, 1, 0, 0, 0, 16'h0, 9'd0, "R1");

      // R3/R4/R5: burst write of control registers, upper byte garbage
      set_ptr(16'h0000, "R3");
      cycle(0, 0, 1, 0, 1, 16'hC37F, 9'd0, "R11");
      for (int i = 1; i <= 12; i++)
         cycle(0, 0, 1, 0, 1, {8'($urandom), 8'(8'h90 + i)}, 9'd0, "R4");
      cycle(0, 0, 1, 0, 1, 16'hAAAA, 9'd0, "R6");
      cycle(0, 0, 1, 0, 1, 16'h5555, 9'd0, "R6");
      set_ptr(16'h0000, "R3");
      for (int i = 0; i <= 14; i++)
         cycle(0, 0, 1, 0, 0, 16'h0, 9'd0, "R5");
      cycle(1, 0, 0, 0, 0, 16'h0, 9'd0, "R2");

      // R6: far unimplemented index
      set_ptr(16'h8001, "R6");
      cycle(0, 0, 1, 0, 1, 16'h00FF, 9'd0, "R6");
      cycle(0, 0, 1, 0, 0, 16'h0, 9'd0, "R6");

      // R2: wrap from 0xFFFF
      set_ptr(16'hFFFF, "R2");
      cycle(0, 0, 1, 0, 0, 16'h0, 9'd0, "R2");
      cycle(1, 0, 0, 0, 0, 16'h0, 9'd0, "R2");
      cycle(0, 1, 0, 0, 0, 16'h0, 9'd0, "R2");

      // R7: burst fill of pattern memory
      set_ptr(16'h0000, "R7");
      for (int i = 0; i < 512; i++)
         cycle(0, 0, 0, 1, 1, 16'($urandom), 9'd0, "R7");
      pix_ok = 1'b1;
      set_ptr(16'h01FE, "R7");
      cycle(0, 0, 0, 1, 0, 16'h0, 9'd0, "R7");
      cycle(0, 0, 0, 1, 0, 16'h0, 9'd0, "R7");

      // R8: index now 0x200, beyond the pattern memory
      cycle(0, 0, 0, 1, 1, 16'hDEAD, 9'd0, "R8");
      set_ptr(16'h0200, "R8");
      cycle(0, 0, 0, 1, 0, 16'h0, 9'd0, "R8");
      cycle(0, 0, 0, 0, 0, 16'h0, 9'd0, "R8");
      set_ptr(16'h0000, "R8");
      cycle(0, 0, 0, 1, 0, 16'h0, 9'd0, "R8");

      // R7: same-cycle host write and pixel read of one word
      set_ptr(16'h0010, "R7");
      cycle(0, 0, 0, 1, 1, 16'hBEEF, 9'h010, "R7");
      cycle(0, 0, 0, 0, 0, 16'h0, 9'h010, "R7");

      // R9: collisions
      set_ptr(16'h0003, "R9");
      cycle(1, 1, 1, 1, 1, 16'h5A5A, 9'd3, "R9");
      cycle(0, 1, 1, 1, 1, 16'h0000, 9'd3, "R9");
      cycle(0, 0, 1, 1, 0, 16'h0, 9'd3, "R9");
      cycle(0, 0, 1, 1, 1, 16'h0077, 9'd3, "R9");
      cycle(1, 0, 0, 0, 0, 16'h0, 9'd3, "R9");
      cycle(0, 1, 0, 0, 0, 16'h0, 9'd3, "R9");

      // Constrained random mix
      for (int n = 0; n < 4000; n++) begin
         int unsigned sel;
         bit a, b, r, m, w;
         logic [15:0] wd;
         string tag;
         sel = $urandom % 16;
         a = (sel == 0); b = (sel == 1);
         r = (sel >= 2 && sel <= 8); m = (sel >= 9 && sel <= 14);
         if ($urandom % 20 == 0) begin
            a = 1'($urandom); b = 1'($urandom); r = 1'($urandom); m = 1'($urandom);
         end
         w = 1'($urandom);
         wd = 16'($urandom);
         if (b && ($urandom % 4 != 0)) wd[7:0] = ($urandom % 2 == 0) ? 8'h00 : 8'h01;
         tag = a ? "R1" : b ? "R1" : r ? "R3" : m ? "R7" : "R2";
         cycle(a, b, r, m, w, wd, 9'($urandom), tag);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule